// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Power-Down Controller

This block sits between the clock synthesis logic and the clock output pins. It gates a set of host clocks and a set of stoppable PCI clocks in response to two active-low stop requests. It also responds to an active-low power-down request that halts every output, including the reference clock and the free-running PCI clock. Each stop request is sampled on the rising edge of the free-running PCI clock. The host request is then resynchronised into the host clock domain.

Every gate changes its enable only while its source clock is low. A gated output therefore always parks at a low level and always resumes with a full-width high phase. Power-down has priority over both stop requests. When power-down is released, the block waits out a settling interval, counted in reference clock cycles, before any clock returns. This interval stands in for the time a synthesiser needs to lock.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `cpu_stop_n` is low, both `host_gclk` outputs stay low. `pci_gclk`, `pcif_gclk` and `ref_gclk` keep toggling.
- R2: A change of `cpu_stop_n` is captured on a rising edge of `pci_clk`. The host outputs stop, or resume, 2 or 3 `host_clk` rising edges after that capturing edge.
- R3: While `pci_stop_n` is low, all `pci_gclk` outputs stay low. `pcif_gclk`, `host_gclk` and `ref_gclk` keep toggling.
- R4: The `pci_clk` rising edge that captures a low `pci_stop_n` still appears on `pci_gclk`, and the next rising edge is suppressed. After `pci_stop_n` returns high, the edge that captures it is suppressed and the following rising edge appears.
- R5: Every high pulse on every gated output lasts exactly one high phase of its source clock. No output is ever left high when it stops.
- R6: `pwrdn_n` passes through a 2-flop synchronizer in the reference domain. `pd_o` is high no later than the 4th `ref_clk` rising edge of a continuous low on `pwrdn_n`. While powered down, the levels of `cpu_stop_n` and `pci_stop_n` have no effect on any output.
- R7: While `pd_o` is high, every gated output (`host_gclk`, `pci_gclk`, `pcif_gclk`, `ref_gclk`) is low once the request has crossed the synchronizers.
- R8: After `pwrdn_n` returns high, all outputs remain low and `pd_o` remains high for at least `SETTLE_CYC` `ref_clk` rising edges. All outputs resume, and `pd_o` falls, within `SETTLE_CYC`+8 rising edges.
- R9: While `rst_n` is low, all gated outputs are low and `pd_o` is high. After reset is released, the block follows the same settling sequence as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host clock source |
| pci_clk | input | 1 | PCI clock source; also the sampling clock for the stop requests |
| ref_clk | input | 1 | Reference clock source; runs the power sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low request to stop the host clocks |
| pci_stop_n | input | 1 | Active-low request to stop the gated PCI clocks |
| pwrdn_n | input | 1 | Asynchronous active-low power-down request |
| host_gclk | output | N_HOST | Gated host clocks |
| pci_gclk | output | N_PCI | Stoppable PCI clocks |
| pcif_gclk | output | 1 | Free-running PCI clock, halted only by power-down |
| ref_gclk | output | 1 | Reference clock, halted only by power-down |
| pd_o | output | 1 | High while powered down or still settling |

## Verification
The assertions assume that the two stop requests change only away from rising edges of `pci_clk`. They also assume that a power-down request is held for at least several reference cycles. Without these conditions the latency windows they check would be ambiguous. The bench drives the stop requests on falling edges of `pci_clk`. It changes `pwrdn_n` and `rst_n` only on falling edges of `ref_clk`, and holds each level for many reference cycles. The three source clocks have fixed phase offsets, so no rising edges of different domains coincide at the points where latency is measured.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // Stop requests as seen on the rising edge of the free-running PCI clock
    typedef struct packed {
        logic pci_hold;   // 1: stoppable PCI clocks held low
        logic host_req;   // 1: host clocks allowed to run
    } pci_samp_t;

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q[STAGES-1];

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    output logic [WIDTH-1:0] gclk
);

    logic en_d, en_q;

    always_comb begin
        en_d = en_req;
    end

    // Enable updates on the falling edge, so it changes only while clk is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_out
        assign gclk[i] = clk & en_q;
    end

endmodule

// File: rtl/clkstop_pwrseq.sv
module clkstop_pwrseq #(
    parameter int SETTLE_CYC  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic pwrdn_n,
    output logic run_o,
    output logic pd_o
);

    localparam int CW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
    } seq_t;

    seq_t seq_d, seq_q;
    logic pwr_ok;

    clkstop_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_pd_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (pwrdn_n),
        .q     (pwr_ok)
    );

    always_comb begin
        seq_d = seq_q;
        if (!pwr_ok) begin
            seq_d.cnt = '0;
            seq_d.run = 1'b0;
        end else if (!seq_q.run) begin
            if (seq_q.cnt == CW'(SETTLE_CYC - 1)) begin
                seq_d.cnt = '0;
                seq_d.run = 1'b1;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign run_o = seq_q.run;
    assign pd_o  = ~seq_q.run;

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_HOST      = 2,
    parameter int N_PCI       = 5,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 64
) (
    input  logic              host_clk,
    input  logic              pci_clk,
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              cpu_stop_n,
    input  logic              pci_stop_n,
    input  logic              pwrdn_n,
    output logic [N_HOST-1:0] host_gclk,
    output logic [N_PCI-1:0]  pci_gclk,
    output logic              pcif_gclk,
    output logic              ref_gclk,
    output logic              pd_o
);

    logic      run_ref;
    logic      run_pci;
    logic      host_run;
    logic      pci_hold;
    pci_samp_t samp_d, samp_q;

    // Reference domain: power-down synchronizer and settling counter
    clkstop_pwrseq #(.SETTLE_CYC(SETTLE_CYC), .SYNC_STAGES(SYNC_STAGES)) u_pwrseq (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .pwrdn_n (pwrdn_n),
        .run_o   (run_ref),
        .pd_o    (pd_o)
    );

    clkstop_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_run_sync (
        .clk   (pci_clk),
        .rst_n (rst_n),
        .d     (run_ref),
        .q     (run_pci)
    );

    // PCI domain: capture both stop requests on the free-running clock
    always_comb begin
        samp_d.pci_hold = ~pci_stop_n;
        samp_d.host_req = run_pci & cpu_stop_n;
    end

    always_ff @(posedge pci_clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
        end else begin
            samp_q <= samp_d;
        end
    end

    assign pci_hold = samp_q.pci_hold;

    // Host domain: resynchronise the host run request
    clkstop_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_host_sync (
        .clk   (host_clk),
        .rst_n (rst_n),
        .d     (samp_q.host_req),
        .q     (host_run)
    );

    clkstop_gate #(.WIDTH(N_HOST)) u_host_gate (
        .clk    (host_clk),
        .rst_n  (rst_n),
        .en_req (host_run),
        .gclk   (host_gclk)
    );

    clkstop_gate #(.WIDTH(N_PCI)) u_pci_gate (
        .clk    (pci_clk),
        .rst_n  (rst_n),
        .en_req (run_pci & ~pci_hold),
        .gclk   (pci_gclk)
    );

    clkstop_gate #(.WIDTH(1)) u_pcif_gate (
        .clk    (pci_clk),
        .rst_n  (rst_n),
        .en_req (run_pci),
        .gclk   (pcif_gclk)
    );

    clkstop_gate #(.WIDTH(1)) u_ref_gate (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .en_req (run_ref),
        .gclk   (ref_gclk)
    );

endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
    parameter int N_HOST = 2,
    parameter int N_PCI  = 5
) (
    input logic              pci_clk,
    input logic              ref_clk,
    input logic              rst_n,
    input logic              cpu_stop_n,
    input logic              pwrdn_n,
    input logic [N_HOST-1:0] host_gclk,
    input logic [N_PCI-1:0]  pci_gclk,
    input logic              pcif_gclk,
    input logic              ref_gclk,
    input logic              pd_o,
    input logic              pci_hold
);

    AST_HOST_HELD_LOW: assert property (@(negedge pci_clk) disable iff (!rst_n)
        (!cpu_stop_n && $past(!cpu_stop_n) && $past(!cpu_stop_n, 2) && $past(!cpu_stop_n, 3))
        |-> (host_gclk == '0)); // R1

    AST_PCI_ONE_EDGE: assert property (@(negedge pci_clk) disable iff (!rst_n)
        (pci_hold && $past(pci_hold)) |-> (pci_gclk == '0)); // R4

    AST_PD_FLAG_RISES: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!pwrdn_n && $past(!pwrdn_n) && $past(!pwrdn_n, 2)) |=> pd_o); // R6

    AST_PD_REF_LOW: assert property (@(negedge ref_clk) disable iff (!rst_n)
        (pd_o && $past(pd_o)) |-> !ref_gclk); // R7

    AST_PD_ALL_LOW: assert property (@(negedge ref_clk) disable iff (!rst_n)
        (pd_o && $past(pd_o) && $past(pd_o, 2) && $past(pd_o, 3) && $past(pd_o, 4))
        |-> (host_gclk == '0 && pci_gclk == '0 && !pcif_gclk)); // R7

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.N_HOST(N_HOST), .N_PCI(N_PCI)) u_chk (
    .pci_clk    (pci_clk),
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .cpu_stop_n (cpu_stop_n),
    .pwrdn_n    (pwrdn_n),
    .host_gclk  (host_gclk),
    .pci_gclk   (pci_gclk),
    .pcif_gclk  (pcif_gclk),
    .ref_gclk   (ref_gclk),
    .pd_o       (pd_o),
    .pci_hold   (pci_hold)
);

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb;

    localparam int SETTLE = 20;
    localparam int NH     = 2;
    localparam int NP     = 5;

    logic host_clk = 1'b0;
    logic pci_clk  = 1'b0;
    logic ref_clk  = 1'b0;
    logic rst_n, cpu_stop_n, pci_stop_n, pwrdn_n;
    logic [NH-1:0] host_gclk;
    logic [NP-1:0] pci_gclk;
    logic pcif_gclk, ref_gclk, pd_o;

    int checks   = 0;
    int failures = 0;

    clkstop_ctrl #(.N_HOST(NH), .N_PCI(NP), .SETTLE_CYC(SETTLE)) u_dut (
        .host_clk   (host_clk),
        .pci_clk    (pci_clk),
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .cpu_stop_n (cpu_stop_n),
        .pci_stop_n (pci_stop_n),
        .pwrdn_n    (pwrdn_n),
        .host_gclk  (host_gclk),
        .pci_gclk   (pci_gclk),
        .pcif_gclk  (pcif_gclk),
        .ref_gclk   (ref_gclk),
        .pd_o       (pd_o)
    );

    // 125 MHz host clock (rising at 4, 12, ...); PCI 16 ns rising at 6 + 16k; ref 24 ns rising at 10 + 24k
    always #4 host_clk = ~host_clk;
    initial begin
        #6;
        forever begin pci_clk = 1'b1; #8; pci_clk = 1'b0; #8; end
    end
    initial begin
        #10;
        forever begin ref_clk = 1'b1; #12; ref_clk = 1'b0; #12; end
    end

    // Pulse counters and full-pulse monitors
    int n_h0 = 0, n_h1 = 0, n_p0 = 0, n_p4 = 0, n_pf = 0, n_rf = 0;
    int runt_h = 0, runt_p = 0, runt_pf = 0, runt_rf = 0;
    time t_h0, t_p0, t_pf, t_rf;
    bit  s_h0 = 0, s_p0 = 0, s_pf = 0, s_rf = 0;

    always @(posedge host_gclk[0]) begin n_h0++; t_h0 = $time; s_h0 = 1; end
    always @(posedge host_gclk[1]) n_h1++;
    always @(posedge pci_gclk[0])  begin n_p0++; t_p0 = $time; s_p0 = 1; end
    always @(posedge pci_gclk[4])  n_p4++;
    always @(posedge pcif_gclk)    begin n_pf++; t_pf = $time; s_pf = 1; end
    always @(posedge ref_gclk)     begin n_rf++; t_rf = $time; s_rf = 1; end
    always @(negedge host_gclk[0]) if (s_h0 && ($time - t_h0) != 4)  runt_h++;
    always @(negedge pci_gclk[0])  if (s_p0 && ($time - t_p0) != 8)  runt_p++;
    always @(negedge pcif_gclk)    if (s_pf && ($time - t_pf) != 8)  runt_pf++;
    always @(negedge ref_gclk)     if (s_rf && ($time - t_rf) != 12) runt_rf++;

    int b_h0, b_h1, b_p0, b_p4, b_pf, b_rf;

    task automatic snap();
        b_h0 = n_h0; b_h1 = n_h1; b_p0 = n_p0; b_p4 = n_p4; b_pf = n_pf; b_rf = n_rf;
    endtask

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic check_rng(input string tag, input int got, input int lo, input int hi);
        checks++;
        if (got < lo || got > hi) begin
            failures++;
            $display("FAIL %s: got=%0d exp=%0d..%0d", tag, got, lo, hi);
        end
    endtask

    // {cpu_stop_n, pci_stop_n, pwrdn_n, host runs, pci runs, pcif runs, ref runs, pd_o}
    localparam logic [7:0] VEC [8] = '{
        8'b1111_1110,
        8'b0110_1110,
        8'b1011_0110,
        8'b0010_0110,
        8'b1100_0001,
        8'b0000_0001,
        8'b0100_0001,
        8'b1111_1110
    };

    task automatic run_all();
        int got;
        int first;
        // Reset state (R9)
        rst_n = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pwrdn_n = 1'b1;
        #50;
        check("R9 host_gclk in reset", int'(host_gclk), 0);
        check("R9 pci_gclk in reset", int'(pci_gclk), 0);
        check("R9 pcif/ref in reset", int'({pcif_gclk, ref_gclk}), 0);
        check("R9 pd_o in reset", int'(pd_o), 1);
        @(negedge ref_clk); rst_n = 1'b1;
        snap();
        repeat (SETTLE) @(posedge ref_clk);
        #1;
        check("R9 outputs held during settle", (n_h0 - b_h0) + (n_p0 - b_p0) + (n_pf - b_pf) + (n_rf - b_rf), 0);
        repeat (12) @(posedge ref_clk);

        // Vector table (R1, R3, R6, R7)
        for (int i = 0; i < 8; i++) begin
            @(negedge pci_clk);
            {cpu_stop_n, pci_stop_n, pwrdn_n} = VEC[i][7:5];
            repeat (SETTLE + 12) @(posedge ref_clk);
            snap();
            repeat (8) @(posedge ref_clk);
            #1;
            check($sformatf("R1 host0 runs vec%0d", i), int'(n_h0 != b_h0), int'(VEC[i][4]));
            check($sformatf("R1 host1 runs vec%0d", i), int'(n_h1 != b_h1), int'(VEC[i][4]));
            check($sformatf("R3 pci runs vec%0d", i), int'((n_p0 != b_p0) && (n_p4 != b_p4)), int'(VEC[i][3]));
            check($sformatf("R7 pcif runs vec%0d", i), int'(n_pf != b_pf), int'(VEC[i][2]));
            check($sformatf("R7 ref runs vec%0d", i), int'(n_rf != b_rf), int'(VEC[i][1]));
            check($sformatf("R6 pd_o vec%0d", i), int'(pd_o), int'(VEC[i][0]));
        end

        // R2: host off latency counted from the capturing PCI edge
        @(negedge pci_clk); cpu_stop_n = 1'b0;
        @(posedge pci_clk);
        snap();
        repeat (6) @(posedge host_clk);
        #1;
        check_rng("R2 host pulses before stop", n_h0 - b_h0, 2, 3);
        check("R1 host parked low", int'(host_gclk), 0);
        // R2: host on latency
        @(negedge pci_clk); cpu_stop_n = 1'b1;
        @(posedge pci_clk);
        snap();
        first = 0;
        for (int k = 1; k <= 6; k++) begin
            @(posedge host_clk);
            #1;
            if (first == 0 && n_h0 != b_h0) first = k;
        end
        check_rng("R2 host restart edge", first, 2, 3);

        // R4: PCI stop takes effect one edge after capture
        @(negedge pci_clk); pci_stop_n = 1'b0;
        @(posedge pci_clk);
        #1;
        check("R4 capturing edge passes", int'(pci_gclk), 31);
        snap();
        repeat (4) @(posedge pci_clk);
        #1;
        check("R4 later edges suppressed", n_p0 - b_p0, 0);
        check("R3 pcif keeps running", int'(n_pf != b_pf), 1);
        @(negedge pci_clk); pci_stop_n = 1'b1;
        @(posedge pci_clk);
        #1;
        check("R4 resume capture edge low", int'(pci_gclk), 0);
        @(posedge pci_clk);
        #1;
        check("R4 resume next edge high", int'(pci_gclk), 31);

        // R6: stop inputs ignored while powered down, then R8 settling
        @(negedge ref_clk); pwrdn_n = 1'b0;
        repeat (4) @(posedge ref_clk);
        #1;
        check("R6 pd_o rises within 4 edges", int'(pd_o), 1);
        repeat (8) @(posedge ref_clk);
        snap();
        @(negedge pci_clk); cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        repeat (3) @(posedge ref_clk);
        @(negedge pci_clk); cpu_stop_n = 1'b1;
        repeat (3) @(posedge ref_clk);
        @(negedge pci_clk); pci_stop_n = 1'b1; cpu_stop_n = 1'b0;
        repeat (3) @(posedge ref_clk);
        @(negedge pci_clk); cpu_stop_n = 1'b1;
        repeat (3) @(posedge ref_clk);
        #1;
        check("R6 stop toggles ignored", (n_h0 - b_h0) + (n_p0 - b_p0) + (n_pf - b_pf) + (n_rf - b_rf), 0);
        check("R7 outputs low in power-down", int'({host_gclk, pci_gclk, pcif_gclk, ref_gclk}), 0);
        @(negedge ref_clk); pwrdn_n = 1'b1;
        snap();
        repeat (SETTLE) @(posedge ref_clk);
        #1;
        check("R8 held low during settle", (n_h0 - b_h0) + (n_p0 - b_p0) + (n_pf - b_pf) + (n_rf - b_rf), 0);
        check("R8 pd_o high during settle", int'(pd_o), 1);
        repeat (8) @(posedge ref_clk);
        #1;
        got = int'(n_h0 != b_h0) + int'(n_p0 != b_p0) + int'(n_pf != b_pf) + int'(n_rf != b_rf);
        check("R8 all outputs resumed", got, 4);
        check("R8 pd_o low after settle", int'(pd_o), 0);

        // R5: every pulse was a full high phase
        check("R5 host full pulses", runt_h, 0);
        check("R5 pci full pulses", runt_p, 0);
        check("R5 pcif full pulses", runt_pf, 0);
        check("R5 ref full pulses", runt_rf, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                #200000;
                failures++;
                $display("FAIL watchdog: got=timeout exp=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule